// File: doc/BRIEF.md
# Next Program Counter Generator

This combinational block chooses the address of the next instruction for a core whose instructions are all 32 bits wide and word aligned. Each cycle it takes the current program counter, the immediate fields of the instruction in hand, the value of a source register and the result of an equality compare between two register operands. A decoded control-flow kind then selects one of four sources for the next address: the sequential successor, a relative branch target, a region-local jump target or a register-held target.

The control-flow kinds act as the block's selection states. SEQ (code 0) falls through. BEQ (code 1) and BNE (code 2) branch on equality and inequality. JMP (code 3) jumps within a region. JAL (code 4) jumps and saves a return address. JREG (code 5) jumps through a register. Codes 6 and 7 are reserved and fall through like SEQ. For each kind the transition is a plain mapping. It either leaves the taken flag low and moves to the successor address, or it raises the taken flag and moves to the computed target. JAL also asks the register file to store the return address in a fixed link register. JREG also flags a register target that is not word aligned. All sums wrap modulo 2^32 and nothing reports an overflow.

Top module: `npc_gen`

## Requirements
- R1: With kind SEQ (code 0) the next PC is the current PC plus 4, taken is 0 and link_we is 0.
- R2: With kind BEQ (code 1) and ops_equal=1 the next PC is (PC+4) + (sign-extended br_off shifted left by 2) and taken is 1. With ops_equal=0 the next PC is PC+4 and taken is 0.
- R3: With kind BNE (code 2) the branch is taken exactly when ops_equal=0, using the same target as R2. Otherwise the next PC is PC+4 and taken is 0.
- R4: br_off is a signed word count relative to PC+4. An offset of +3 lands 12 bytes past PC+4 and an offset of -3 (0xFFFD) lands 12 bytes before it.
- R5: With kind JMP (code 3) the next PC is {(PC+4)[31:28], jmp_field, 2'b00}, taken is 1, and the upper four bits come from PC+4 and not from PC.
- R6: Kind JAL (code 4) produces the same target as R5 and also drives link_we=1, link_addr=PC+4 and link_dest=31. link_we is 0 for every other kind.
- R7: With kind JREG (code 5) the next PC is the full reg_target value and taken is 1. misalign is 1 exactly when the kind is JREG and reg_target[1:0] is not 0.
- R8: Every address sum wraps modulo 2^32. For example, PC=0xFFFFFFFC falls through to 0x00000000.
- R9: Reserved kinds 6 and 7 behave as SEQ whatever ops_equal is: the next PC is PC+4, taken is 0 and link_we is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_pc | input | 32 | Address of the current instruction |
| br_off | input | 16 | Signed branch displacement in words |
| jmp_field | input | 26 | Word index for region-local jumps |
| reg_target | input | 32 | Register value used by JREG |
| ops_equal | input | 1 | 1 when the two compared register operands are equal |
| flow_kind | input | 3 | Control-flow kind: 0 SEQ, 1 BEQ, 2 BNE, 3 JMP, 4 JAL, 5 JREG, 6-7 reserved |
| next_pc | output | 32 | Address of the next instruction |
| taken | output | 1 | 1 when control leaves the sequential path |
| link_addr | output | 32 | Return address (PC+4) |
| link_we | output | 1 | Write enable for the return address |
| link_dest | output | 5 | Register index that receives the return address |
| misalign | output | 1 | JREG target is not word aligned |

## Verification
Two cases can land in the same evaluation. A JAL can carry the PC into a new 256 MB region, which updates both the jump target's upper bits and the link address from one PC+4. A JREG can redirect and raise misalign together. The bench therefore puts PC=0x0FFFFFFC on a jump, so that PC+4 crosses the region boundary. It then expects the new region in next_pc and checks link_addr against the same incremented value. For JREG it drives an unaligned register value and expects next_pc to follow that value bit for bit while misalign is high.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_BEQ  = 3'd1,
        FLOW_BNE  = 3'd2,
        FLOW_JMP  = 3'd3,
        FLOW_JAL  = 3'd4,
        FLOW_JREG = 3'd5
    } flow_e;

    localparam int unsigned FLOW_W = 3;

endpackage

// File: rtl/npc_adders.sv
module npc_adders #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OFF_W = 16
) (
    input  logic [XLEN-1:0]  pc_in,
    input  logic [OFF_W-1:0] offset,
    output logic [XLEN-1:0]  pc_plus4,
    output logic [XLEN-1:0]  branch_dst
);
    localparam int unsigned EXT_W = XLEN - OFF_W - 2;

    logic [XLEN-1:0] byte_disp;

    // word count -> sign-extended byte displacement
    assign byte_disp  = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
    assign pc_plus4   = pc_in + XLEN'(4);
    assign branch_dst = pc_plus4 + byte_disp;
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
(
    input  flow_e kind,
    input  logic  eq,
    output logic  redirect
);
    always_comb begin
        unique case (kind)
            FLOW_BEQ:  redirect = eq;
            FLOW_BNE:  redirect = !eq;
            FLOW_JMP,
            FLOW_JAL,
            FLOW_JREG: redirect = 1'b1;
            default:   redirect = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned JF_W = 26
) (
    input  flow_e            kind,
    input  logic             redirect,
    input  logic [XLEN-1:0]  pc_plus4,
    input  logic [XLEN-1:0]  branch_dst,
    input  logic [JF_W-1:0]  field,
    input  logic [XLEN-1:0]  reg_val,
    output logic [XLEN-1:0]  npc
);
    localparam int unsigned REGION_W = XLEN - JF_W - 2;

    logic [XLEN-1:0] region_dst;

    // region bits taken from the incremented PC
    assign region_dst = {pc_plus4[XLEN-1 -: REGION_W], field, 2'b00};

    always_comb begin
        npc = pc_plus4;
        if (redirect) begin
            unique case (kind)
                FLOW_BEQ, FLOW_BNE: npc = branch_dst;
                FLOW_JMP, FLOW_JAL: npc = region_dst;
                FLOW_JREG:          npc = reg_val;
                default:            npc = pc_plus4;
            endcase
        end
    end
endmodule

// File: rtl/npc_gen.sv
module npc_gen
    import npc_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned OFF_W    = 16,
    parameter int unsigned JF_W     = 26,
    parameter int unsigned RIDX_W   = 5,
    parameter int unsigned LINK_REG = 31
) (
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [OFF_W-1:0]  br_off,
    input  logic [JF_W-1:0]   jmp_field,
    input  logic [XLEN-1:0]   reg_target,
    input  logic              ops_equal,
    input  logic [2:0]        flow_kind,
    output logic [XLEN-1:0]   next_pc,
    output logic              taken,
    output logic [XLEN-1:0]   link_addr,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_dest,
    output logic              misalign
);
    flow_e           kind;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] branch_dst;
    logic            redirect;

    assign kind = flow_e'(flow_kind);

    npc_adders #(.XLEN(XLEN), .OFF_W(OFF_W)) u_add (
        .pc_in      (cur_pc),
        .offset     (br_off),
        .pc_plus4   (pc_plus4),
        .branch_dst (branch_dst)
    );

    npc_cond u_cond (
        .kind     (kind),
        .eq       (ops_equal),
        .redirect (redirect)
    );

    npc_select #(.XLEN(XLEN), .JF_W(JF_W)) u_sel (
        .kind       (kind),
        .redirect   (redirect),
        .pc_plus4   (pc_plus4),
        .branch_dst (branch_dst),
        .field      (jmp_field),
        .reg_val    (reg_target),
        .npc        (next_pc)
    );

    assign taken     = redirect;
    assign link_addr = pc_plus4;
    assign link_we   = (kind == FLOW_JAL);
    assign link_dest = RIDX_W'(LINK_REG);
    assign misalign  = (kind == FLOW_JREG) && (reg_target[1:0] != 2'b00);
endmodule

// File: rtl/npc_gen_check.sv
module npc_gen_check #(
    parameter int unsigned XLEN = 32
) (
    input logic [XLEN-1:0] cur_pc,
    input logic [XLEN-1:0] reg_target,
    input logic [2:0]      flow_kind,
    input logic [XLEN-1:0] next_pc,
    input logic            taken,
    input logic [XLEN-1:0] link_addr,
    input logic            link_we,
    input logic            misalign
);
    logic [XLEN-1:0] succ;
    assign succ = cur_pc + XLEN'(4);

    always_comb begin
        if (!$isunknown({cur_pc, reg_target, flow_kind, next_pc, taken,
                         link_addr, link_we, misalign})) begin
            if (flow_kind == 3'd0)
                assert_seq_fall_R1: assert (next_pc == succ && !taken && !link_we);
            if (!taken)
                assert_untaken_succ_R2: assert (next_pc == succ);
            if (flow_kind == 3'd3 || flow_kind == 3'd4)
                assert_region_bits_R5: assert (next_pc[XLEN-1 -: 4] == succ[XLEN-1 -: 4]
                                               && next_pc[1:0] == 2'b00 && taken);
            if (link_we)
                assert_link_only_jal_R6: assert (flow_kind == 3'd4 && link_addr == succ);
            if (flow_kind == 3'd5)
                assert_jreg_full_R7: assert (next_pc == reg_target && taken);
            if (misalign)
                assert_misalign_src_R7: assert (flow_kind == 3'd5 && reg_target[1:0] != 2'b00);
            if (flow_kind[2:1] == 2'b11)
                assert_reserved_seq_R9: assert (!taken && !link_we && !misalign);
        end
    end
endmodule

bind npc_gen npc_gen_check #(.XLEN(XLEN)) u_npc_check (
    .cur_pc     (cur_pc),
    .reg_target (reg_target),
    .flow_kind  (flow_kind),
    .next_pc    (next_pc),
    .taken      (taken),
    .link_addr  (link_addr),
    .link_we    (link_we),
    .misalign   (misalign)
);

// File: tb/npc_gen_test.sv
module npc_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_field = '0;
    logic [31:0] reg_target = '0;
    logic        ops_equal = 1'b0;
    logic [2:0]  flow_kind = '0;
    logic [31:0] next_pc;
    logic        taken;
    logic [31:0] link_addr;
    logic        link_we;
    logic [4:0]  link_dest;
    logic        misalign;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    npc_gen uut (
        .cur_pc(cur_pc), .br_off(br_off), .jmp_field(jmp_field),
        .reg_target(reg_target), .ops_equal(ops_equal), .flow_kind(flow_kind),
        .next_pc(next_pc), .taken(taken), .link_addr(link_addr),
        .link_we(link_we), .link_dest(link_dest), .misalign(misalign)
    );

    // pc, off, field, reg, eq, kind, expected next, expected taken
    localparam int NV = 12;
    localparam logic [142:0] VEC [NV] = '{
        {32'h0040_0000, 16'h0000, 26'h0, 32'h0, 1'b0, 3'd0, 32'h0040_0004, 1'b0}, // R1
        {32'h0040_0010, 16'h0003, 26'h0, 32'h0, 1'b1, 3'd1, 32'h0040_0020, 1'b1}, // R2 R4
        {32'h0040_0010, 16'h0003, 26'h0, 32'h0, 1'b0, 3'd1, 32'h0040_0014, 1'b0}, // R2
        {32'h0040_0010, 16'hFFFD, 26'h0, 32'h0, 1'b0, 3'd2, 32'h0040_0008, 1'b1}, // R3 R4
        {32'h0040_0010, 16'hFFFD, 26'h0, 32'h0, 1'b1, 3'd2, 32'h0040_0014, 1'b0}, // R3
        {32'h0FFF_FFFC, 16'h0000, 26'h10, 32'h0, 1'b0, 3'd3, 32'h1000_0040, 1'b1}, // R5
        {32'h0040_0020, 16'h0000, 26'h3FF_FFFF, 32'h0, 1'b0, 3'd4, 32'h0FFF_FFFC, 1'b1}, // R6
        {32'h0040_0020, 16'h0000, 26'h0, 32'h1234_5678, 1'b0, 3'd5, 32'h1234_5678, 1'b1}, // R7
        {32'hFFFF_FFFC, 16'h0000, 26'h0, 32'h0, 1'b0, 3'd0, 32'h0000_0000, 1'b0}, // R8
        {32'hFFFF_FFF8, 16'h0004, 26'h0, 32'h0, 1'b1, 3'd1, 32'h0000_000C, 1'b1}, // R8
        {32'h0000_0100, 16'h0008, 26'h55, 32'h3, 1'b1, 3'd6, 32'h0000_0104, 1'b0}, // R9
        {32'h0000_0100, 16'h0008, 26'h55, 32'h3, 1'b0, 3'd7, 32'h0000_0104, 1'b0}  // R9
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] pc, input logic [15:0] off, input logic [25:0] fld,
                         input logic [31:0] rv, input logic eq, input logic [2:0] kd);
        @(negedge clk);
        cur_pc = pc; br_off = off; jmp_field = fld;
        reg_target = rv; ops_equal = eq; flow_kind = kd;
        #1;
    endtask

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // idle state, all inputs zero: R1
        #1;
        check32("R1 idle next_pc", next_pc, 32'h4);
        check32("R1 idle taken", {31'b0, taken}, 32'h0);
        check32("R1 idle link_we", {31'b0, link_we}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][142:111], VEC[i][110:95], VEC[i][94:69],
                  VEC[i][68:37], VEC[i][36], VEC[i][35:33]);
            check32($sformatf("R1-9 vec%0d next_pc", i), next_pc, VEC[i][32:1]);
            check32($sformatf("R1-9 vec%0d taken", i), {31'b0, taken}, {31'b0, VEC[i][0]});
        end

        // R6: link outputs on JAL across a region boundary
        apply(32'h0FFF_FFFC, 16'h0, 26'h1, 32'h0, 1'b0, 3'd4);
        check32("R6 jal next_pc", next_pc, 32'h1000_0004);
        check32("R6 jal link_we", {31'b0, link_we}, 32'h1);
        check32("R6 jal link_addr", link_addr, 32'h1000_0000);
        check32("R6 jal link_dest", {27'b0, link_dest}, 32'd31);
        // R6: plain jump writes no link
        apply(32'h0FFF_FFFC, 16'h0, 26'h1, 32'h0, 1'b0, 3'd3);
        check32("R6 jmp link_we", {31'b0, link_we}, 32'h0);
        check32("R5 jmp region", next_pc, 32'h1000_0004);

        // R7: unaligned register target
        apply(32'h0000_2000, 16'h0, 26'h0, 32'h8000_0002, 1'b0, 3'd5);
        check32("R7 jreg next_pc", next_pc, 32'h8000_0002);
        check32("R7 jreg misalign", {31'b0, misalign}, 32'h1);
        apply(32'h0000_2000, 16'h0, 26'h0, 32'h8000_0001, 1'b0, 3'd5);
        check32("R7 jreg misalign bit0", {31'b0, misalign}, 32'h1);
        apply(32'h0000_2000, 16'h0, 26'h0, 32'h8000_0004, 1'b0, 3'd5);
        check32("R7 jreg aligned", {31'b0, misalign}, 32'h0);
        // R7: misalign ignored outside JREG
        apply(32'h0000_2000, 16'h0, 26'h0, 32'h8000_0003, 1'b1, 3'd1);
        check32("R7 beq no misalign", {31'b0, misalign}, 32'h0);
        check32("R2 beq with unaligned reg", next_pc, 32'h0000_2004);

        // R8: JAL link address wraps at top of memory
        apply(32'hFFFF_FFFC, 16'h0, 26'h2, 32'h0, 1'b0, 3'd4);
        check32("R8 link wrap", link_addr, 32'h0000_0000);
        check32("R8 jal wrap target", next_pc, 32'h0000_0008);

        // R9: reserved code never links
        apply(32'h0000_0100, 16'h0, 26'h0, 32'h0, 1'b1, 3'd7);
        check32("R9 reserved link_we", {31'b0, link_we}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule